// File: doc/BRIEF.md
# Receive FIFO Status Generator

This block produces the 2-bit flow-control status that a packet receiver sends back to its transmitter, one port per clock. For each port it compares the buffer fill level, in bytes, against two shared thresholds. Below the lower threshold a port is starving. At or above the upper threshold it is satisfied. Anywhere between, it is hungry.

When the static override input is high, the status no longer comes from the fill levels. It comes from a per-port status RAM that external logic fills through a strobe, an 8-bit port address and a 2-bit code. The scan walks the provisioned ports in ascending order and wraps. Each emitted code carries a port tag. A static select chooses whether the output changes on the rising or the falling clock edge.

Top module: `rx_fifo_status_gen`

## Requirements
- R1: With override low, a port whose fill is below `thr_empty` is reported as code 00 (starving), and code 11 is never produced.
- R2: With override low, a port whose fill is at least `thr_empty` and below `thr_full` is reported as code 01 (hungry).
- R3: With override low, a port whose fill is at least `thr_full` is reported as code 10 (satisfied), even when `thr_empty` exceeds `thr_full`.
- R4: The port tag steps 0, 1, … up to the effective count minus 1, advancing by one each clock, and then wraps to 0. Each emitted code belongs to the tagged port.
- R5: A `port_count` of 0 holds the scan on port 0. A count above NUM_PORTS is treated as NUM_PORTS.
- R6: With override high, each port's code is the last value written to its RAM entry by a cycle with `ovr_valid` high. Writes may come in any address order, and the code is passed through unchanged.
- R7: With override low, `ovr_valid`, `ovr_port` and `ovr_code` have no effect on the output, and nothing is stored in the RAM.
- R8: A write to an address at or above the effective count is stored, but that port is never emitted until the count grows to include it.
- R9: With `rise_sel` at 1, the output changes on the rising edge. With `rise_sel` at 0, it changes on the following falling edge, half a clock later.
- R10: While reset is held, the outputs read code 11 with port tag 0, and every RAM entry is cleared to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_level | input | NUM_PORTS*FILL_W | Per-port buffer fill in bytes, port p at bits [p*FILL_W +: FILL_W] |
| thr_empty | input | FILL_W | Starving/hungry boundary in bytes (static) |
| thr_full | input | FILL_W | Hungry/satisfied boundary in bytes (static) |
| port_count | input | CNT_W | Number of provisioned ports |
| ovr_en | input | 1 | Static: status taken from the RAM instead of the fill levels |
| ovr_valid | input | 1 | External status write strobe |
| ovr_port | input | ADDR_W | External status write address |
| ovr_code | input | 2 | External status value |
| rise_sel | input | 1 | Static: 1 = rising-edge output, 0 = falling-edge output |
| status_o | output | 2 | Status code for the tagged port |
| port_o | output | IDX_W | Port the current status belongs to |

## Verification
The code for the scanned port is registered at a rising edge. In rising mode it appears at that edge; in falling mode it appears at the next falling edge. A RAM write lands at the rising edge after the strobe and is read in the scan from that edge on. After any change to the fills, thresholds, count, override or writes, the bench waits three clocks. It then samples 1 ns before each rising edge, when both edge modes have settled. The edge test also samples 1 ns after the rising edge, so it can tell the two modes apart.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    typedef enum logic [1:0] {
        ST_STARVE = 2'b00,
        ST_HUNGRY = 2'b01,
        ST_SATED  = 2'b10,
        ST_FRAME  = 2'b11
    } fifo_stat_e;
endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
    import rxstat_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int FILL_W    = 16
) (
    input  logic [NUM_PORTS*FILL_W-1:0] fill_i,
    input  logic [FILL_W-1:0]           ae_i,
    input  logic [FILL_W-1:0]           af_i,
    output logic [NUM_PORTS*2-1:0]      class_o
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [FILL_W-1:0] lvl;
        assign lvl = fill_i[g*FILL_W +: FILL_W];
        always_comb begin
            if (lvl >= af_i)      class_o[g*2 +: 2] = ST_SATED;
            else if (lvl < ae_i)  class_o[g*2 +: 2] = ST_STARVE;
            else                  class_o[g*2 +: 2] = ST_HUNGRY;
        end
    end
endmodule

// File: rtl/rxstat_scan.sv
module rxstat_scan #(
    parameter int NUM_PORTS = 8,
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } scan_t;

    scan_t            scan_d, scan_q;
    logic [CNT_W-1:0] eff_cnt;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        eff_cnt  = (count_i > CNT_W'(NUM_PORTS)) ? CNT_W'(NUM_PORTS) : count_i;
        last_idx = (eff_cnt == '0) ? '0 : IDX_W'(eff_cnt - CNT_W'(1));
        scan_d   = scan_q;
        if (scan_q.idx >= last_idx) scan_d.idx = '0;
        else                        scan_d.idx = scan_q.idx + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign idx_o = scan_q.idx;

    // R4: wrap to port 0 after the last provisioned port
    p_scan_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q.idx >= last_idx) |=> (scan_q.idx == '0));

    // R4: one port per clock
    p_scan_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q.idx < last_idx) |=> (scan_q.idx == $past(scan_q.idx) + IDX_W'(1)));
endmodule

// File: rtl/rxstat_ram.sv
module rxstat_ram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [1:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [1:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [1:0] mem_d [DEPTH];
    logic [1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 2'b00;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R6: a write lands in the addressed entry
    p_ram_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rxstat_edge_out.sv
module rxstat_edge_out #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_sel_i,
    input  logic [1:0]       stat_i,
    input  logic [IDX_W-1:0] port_i,
    output logic [1:0]       stat_o,
    output logic [IDX_W-1:0] port_o
);
    typedef struct packed {
        logic [1:0]       stat;
        logic [IDX_W-1:0] port;
    } out_t;

    out_t neg_d, neg_q;

    always_comb begin
        neg_d.stat = stat_i;
        neg_d.port = port_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= '{stat: 2'b11, port: '0};
        else        neg_q <= neg_d;
    end

    assign stat_o = rise_sel_i ? stat_i : neg_q.stat;
    assign port_o = rise_sel_i ? port_i : neg_q.port;
endmodule

// File: rtl/rx_fifo_status_gen.sv
module rx_fifo_status_gen
    import rxstat_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int FILL_W    = 16,
    parameter int ADDR_W    = 8,
    localparam int CNT_W    = $clog2(NUM_PORTS + 1),
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*FILL_W-1:0] fill_level,
    input  logic [FILL_W-1:0]           thr_empty,
    input  logic [FILL_W-1:0]           thr_full,
    input  logic [CNT_W-1:0]            port_count,
    input  logic                        ovr_en,
    input  logic                        ovr_valid,
    input  logic [ADDR_W-1:0]           ovr_port,
    input  logic [1:0]                  ovr_code,
    input  logic                        rise_sel,
    output logic [1:0]                  status_o,
    output logic [IDX_W-1:0]            port_o
);
    typedef struct packed {
        logic [1:0]       stat;
        logic [IDX_W-1:0] port;
    } pipe_t;

    logic [NUM_PORTS*2-1:0] class_vec;
    logic [IDX_W-1:0]       scan_idx;
    logic [1:0]             ram_rd;
    logic                   ram_we;
    pipe_t                  pipe_d, pipe_q;

    rxstat_classify #(.NUM_PORTS(NUM_PORTS), .FILL_W(FILL_W)) u_classify (
        .fill_i  (fill_level),
        .ae_i    (thr_empty),
        .af_i    (thr_full),
        .class_o (class_vec)
    );

    rxstat_scan #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (port_count),
        .idx_o   (scan_idx)
    );

    assign ram_we = ovr_en & ovr_valid;

    rxstat_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .waddr_i (ovr_port),
        .wdata_i (ovr_code),
        .raddr_i (ADDR_W'(scan_idx)),
        .rdata_o (ram_rd)
    );

    always_comb begin
        pipe_d.port = scan_idx;
        pipe_d.stat = ovr_en ? ram_rd : class_vec[2*scan_idx +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '{stat: ST_FRAME, port: '0};
        else        pipe_q <= pipe_d;
    end

    rxstat_edge_out #(.IDX_W(IDX_W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_sel_i (rise_sel),
        .stat_i     (pipe_q.stat),
        .port_i     (pipe_q.port),
        .stat_o     (status_o),
        .port_o     (port_o)
    );

    // R1: threshold mode never yields the reserved framing code
    p_no_frame_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_en |=> (pipe_q.stat != ST_FRAME));
endmodule

// File: tb/test_rx_fifo_status_gen.sv
module test_rx_fifo_status_gen;
    localparam int NP = 8;
    localparam int FW = 16;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic [NP*FW-1:0] fill_level;
    logic [FW-1:0]   thr_empty, thr_full;
    logic [CW-1:0]   port_count;
    logic            ovr_en, ovr_valid, rise_sel;
    logic [AW-1:0]   ovr_port;
    logic [1:0]      ovr_code;
    logic [1:0]      status_o;
    logic [IW-1:0]   port_o;

    rx_fifo_status_gen #(.NUM_PORTS(NP), .FILL_W(FW), .ADDR_W(AW)) i_rx_fifo_status_gen (
        .clk(clk), .rst_n(rst_n), .fill_level(fill_level), .thr_empty(thr_empty),
        .thr_full(thr_full), .port_count(port_count), .ovr_en(ovr_en),
        .ovr_valid(ovr_valid), .ovr_port(ovr_port), .ovr_code(ovr_code),
        .rise_sel(rise_sel), .status_o(status_o), .port_o(port_o)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] exp_ram [256];

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cls(int f);
        if (f >= int'(thr_full)) return 2;
        if (f < int'(thr_empty)) return 0;
        return 1;
    endfunction

    function automatic int fill_of(int p);
        return int'(fill_level[p*FW +: FW]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (3) tick();
    endtask

    task automatic sample();
        tick();
        #2;
    endtask

    task automatic set_fill(int p, int v);
        fill_level[p*FW +: FW] = FW'(v);
    endtask

    task automatic ext_write(int a, int c, bit track);
        tick();
        ovr_valid = 1'b1;
        ovr_port  = AW'(a);
        ovr_code  = 2'(c);
        tick();
        ovr_valid = 1'b0;
        if (track) exp_ram[a] = 2'(c);
    endtask

    task automatic run_scan(int n, int eff, string seq_req);
        int prev = -1;
        for (int i = 0; i < n; i++) begin
            int p;
            int e;
            string tag;
            sample();
            p = int'(port_o);
            if (ovr_en) begin
                e = int'(exp_ram[p]);
                tag = "R6";
            end else begin
                e = cls(fill_of(p));
                tag = (e == 0) ? "R1" : (e == 1) ? "R2" : "R3";
            end
            chk(tag, int'(status_o), e);
            if (prev >= 0) chk(seq_req, p, (prev + 1) % eff);
            prev = p;
        end
    endtask

    task automatic do_reset(bit rise);
        rst_n = 1'b0;
        rise_sel = rise;
        repeat (2) tick();
        #1;
        chk("R10", int'(status_o), 3);
        chk("R10", int'(port_o), 0);
        for (int i = 0; i < 256; i++) exp_ram[i] = 2'b00;
        rst_n = 1'b1;
    endtask

    task automatic t_classify();
        thr_empty = 16'd100;
        thr_full  = 16'd200;
        port_count = 4'd8;
        set_fill(0, 0);    set_fill(1, 99);  set_fill(2, 100); set_fill(3, 199);
        set_fill(4, 200);  set_fill(5, 65535); set_fill(6, 150); set_fill(7, 50);
        settle();
        run_scan(16, 8, "R4");
        // R3: inverted thresholds, the upper boundary takes precedence
        thr_empty = 16'd300;
        thr_full  = 16'd100;
        settle();
        run_scan(8, 8, "R4");
        thr_empty = 16'd100;
        thr_full  = 16'd200;
    endtask

    task automatic t_count();
        port_count = 4'd3;
        settle();
        run_scan(9, 3, "R4");
        port_count = 4'd0;
        settle();
        run_scan(6, 1, "R5");
        port_count = 4'd15;
        settle();
        run_scan(12, 8, "R5");
        port_count = 4'd8;
    endtask

    task automatic t_ignore();
        for (int p = 0; p < NP; p++) set_fill(p, 150);
        ovr_en = 1'b0;
        ext_write(2, 2, 1'b0);
        ext_write(6, 3, 1'b0);
        settle();
        run_scan(8, 8, "R7");
        // R7: nothing was stored, entries still read their cleared value
        ovr_en = 1'b1;
        settle();
        for (int i = 0; i < 8; i++) begin
            sample();
            chk("R7", int'(status_o), 0);
        end
        ovr_en = 1'b0;
    endtask

    task automatic t_override();
        ovr_en = 1'b1;
        for (int p = 0; p < NP; p++) set_fill(p, 500);
        ext_write(5, 1, 1'b1); ext_write(0, 2, 1'b1); ext_write(7, 3, 1'b1);
        ext_write(2, 1, 1'b1); ext_write(6, 2, 1'b1); ext_write(1, 3, 1'b1);
        ext_write(4, 1, 1'b1); ext_write(3, 2, 1'b1); ext_write(0, 1, 1'b1);
        settle();
        run_scan(16, 8, "R6");
    endtask

    task automatic t_unprov();
        port_count = 4'd3;
        ext_write(5, 2, 1'b1);
        ext_write(200, 3, 1'b1);
        settle();
        run_scan(9, 3, "R8");
        port_count = 4'd8;
        settle();
        for (int i = 0; i < 8; i++) begin
            sample();
            if (port_o == 3'd5) chk("R8", int'(status_o), 2);
        end
        ovr_en = 1'b0;
    endtask

    task automatic t_edge(bit rise);
        do_reset(rise);
        port_count = 4'd8;
        set_fill(0, 0); set_fill(1, 150); set_fill(2, 300); set_fill(3, 99);
        set_fill(4, 100); set_fill(5, 200); set_fill(6, 10); set_fill(7, 199);
        settle();
        for (int i = 0; i < 8; i++) begin
            int a;
            int b;
            @(posedge clk);
            #1 a = int'(port_o);
            #2 b = int'(port_o);
            chk("R9", b, rise ? a : (a + 1) % 8);
            chk("R9", int'(status_o), cls(fill_of(b)));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fill_level = '0;
        thr_empty = 16'd100;
        thr_full = 16'd200;
        port_count = 4'd8;
        ovr_en = 1'b0;
        ovr_valid = 1'b0;
        ovr_port = '0;
        ovr_code = '0;
        rise_sel = 1'b1;
        do_reset(1'b1);
        t_classify();
        t_count();
        t_ignore();
        t_override();
        t_unprov();
        t_edge(1'b0);
        t_edge(1'b1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule